// File: doc/BRIEF.md
# Count-Tagged Transaction Commit Checker

This block lets a persistent log prove that a transaction committed without a separate commit record. On the write path it tags every data block headed for the log with the writer's transaction ID and a count field. The count is zero on every block except the one flagged as the transaction's final block. That block carries the number of blocks the transaction logged. A per-ID running counter supplies the value, so blocks of different transactions may be interleaved.

On the recovery path the block accepts a stream of log entries, bracketed by a start pulse and an end pulse. For each transaction ID it tallies the entries found and keeps the non-zero count it saw. When the end pulse arrives, it can state for any ID whether that ID was seen and whether it committed. An ID is committed when exactly one non-zero count was found, that count equals the number of entries, and the tally did not overflow. The order of entries within the log carries no meaning. Verdicts are read out one ID per cycle through a registered read port.

Top module: `txcnt_commit_top`

## Requirements
- R1: Each cycle with `lw_valid` high produces, one cycle later, `tag_valid` high with `tag_id`, `tag_last` and `tag_data` equal to the accepted block's values; a cycle with no block gives `tag_valid` low one cycle later.
- R2: A tagged block whose input had `lw_last` low carries `tag_cnt` = 0.
- R3: A tagged block whose input had `lw_last` high carries `tag_cnt` = (number of blocks of that ID since its previous last block, this one included) modulo 2^CNT_W. Each ID keeps its own tally, so IDs may interleave freely.
- R4: A `scan_start` pulse clears every slot and drives `scan_done` low on the next cycle. An entry presented in the same cycle as `scan_start` is dropped.
- R5: After a scan, an ID with at least one entry reads `rd_seen` = 1. Its `rd_commit` is 1 exactly when one entry carried a non-zero count and that count equals the number of entries bearing the ID.
- R6: The position of the non-zero-count entry within a transaction's entries, and the interleaving of different IDs in the scan, do not change any verdict.
- R7: An ID whose entries carry no non-zero count, or carry two or more, reads `rd_commit` = 0 with `rd_seen` = 1.
- R8: An ID with more than 2^CNT_W − 1 entries reads `rd_commit` = 0, even when its wrapped tally equals its recorded count. An ID with exactly 2^CNT_W − 1 entries and a matching count commits.
- R9: `scan_end` sets `scan_done` on the next cycle. `rd_seen`/`rd_commit` reflect `rd_id` one cycle after it is presented, and read 0/0 while `scan_done` is low or for an ID with no entries.
- R10: After reset, `tag_valid`, `scan_done`, `rd_seen` and `rd_commit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lw_valid | input | 1 | Log block offered on the write path |
| lw_id | input | ID_W | Transaction ID of the block |
| lw_last | input | 1 | Block is the transaction's final block |
| lw_data | input | DATA_W | Block payload |
| tag_valid | output | 1 | Tagged log entry valid |
| tag_id | output | ID_W | Transaction ID tag |
| tag_cnt | output | CNT_W | Count tag (non-zero only on the final block) |
| tag_last | output | 1 | Copy of the final-block flag |
| tag_data | output | DATA_W | Payload |
| scan_start | input | 1 | Begin a recovery scan (clears the table) |
| scan_valid | input | 1 | Scanned log entry valid |
| scan_id | input | ID_W | Scanned entry's transaction ID |
| scan_cnt | input | CNT_W | Scanned entry's count tag |
| scan_end | input | 1 | Recovery scan complete |
| scan_done | output | 1 | Verdicts are valid |
| rd_id | input | ID_W | ID whose verdict is requested |
| rd_seen | output | 1 | Requested ID had at least one entry |
| rd_commit | output | 1 | Requested ID committed |

## Verification
Every result has a one-cycle latency. A tagged entry follows its input block by one cycle. `scan_done` follows `scan_end` by one cycle, and `rd_seen`/`rd_commit` follow `rd_id` by one cycle. The bench drives all inputs on the falling edge and samples outputs on the next falling edge, so each sample falls exactly one rising edge after its stimulus. Expected tags come from a per-ID running tally kept in the bench. Expected verdicts come from recounting the entry list the bench itself sent, after a random shuffle.

// File: rtl/txcnt_pkg.sv
`timescale 1ns/1ps
package txcnt_pkg;

   // How many non-zero count tags a slot has observed during a scan
   typedef enum logic [1:0] {
      REC_NONE = 2'd0,
      REC_ONE  = 2'd1,
      REC_MANY = 2'd2
   } rec_state_e;

   // Saturating step of the observed-count state
   function automatic rec_state_e rec_step(input rec_state_e cur);
      case (cur)
         REC_NONE: rec_step = REC_ONE;
         default:  rec_step = REC_MANY;
      endcase
   endfunction

endpackage

// File: rtl/txcnt_tagger.sv
`timescale 1ns/1ps
module txcnt_tagger
   import txcnt_pkg::*;
#(
   parameter int ID_W    = 4,
   parameter int CNT_W   = 8,
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lw_valid_i,
   input  logic [ID_W-1:0]   lw_id_i,
   input  logic              lw_last_i,
   input  logic [DATA_W-1:0] lw_data_i,
   output logic              tag_valid_o,
   output logic [ID_W-1:0]   tag_id_o,
   output logic [CNT_W-1:0]  tag_cnt_o,
   output logic              tag_last_o,
   output logic [DATA_W-1:0] tag_data_o
);
   localparam int SLOTS = 1 << ID_W;

   initial begin : param_chk
      assert (ID_W >= 1 && ID_W <= 8) else $error("tagger: ID_W out of range");
      assert (CNT_W >= 2) else $error("tagger: CNT_W too small");
      assert (DATA_W >= 1) else $error("tagger: DATA_W must be positive");
   end

   // Blocks logged so far by each ID since its last final block
   logic [CNT_W-1:0] run_q [SLOTS];
   logic [CNT_W-1:0] run_cur;
   logic [CNT_W-1:0] cnt_nxt;

   genvar g;
   generate
      for (g = 0; g < SLOTS; g++) begin : g_run
         logic [CNT_W-1:0] run_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_r <= '0;
            end else if (lw_valid_i && (lw_id_i == ID_W'(g))) begin
               run_r <= lw_last_i ? '0 : run_r + 1'b1;
            end
         end
         assign run_q[g] = run_r;
      end
   endgenerate

   always_comb begin
      run_cur = run_q[lw_id_i];
      cnt_nxt = lw_last_i ? run_cur + 1'b1 : '0;
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tag_valid_o <= 1'b0;
               tag_id_o    <= '0;
               tag_cnt_o   <= '0;
               tag_last_o  <= 1'b0;
               tag_data_o  <= '0;
            end else begin
               tag_valid_o <= lw_valid_i;
               if (lw_valid_i) begin
                  tag_id_o   <= lw_id_i;
                  tag_cnt_o  <= cnt_nxt;
                  tag_last_o <= lw_last_i;
                  tag_data_o <= lw_data_i;
               end
            end
         end

         // R1
         tag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lw_valid_i |=> (tag_valid_o && tag_id_o == $past(lw_id_i)
                            && tag_data_o == $past(lw_data_i)));
         // R2
         inner_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lw_valid_i && !lw_last_i) |=> (tag_cnt_o == '0));
         // R3
         final_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lw_valid_i && lw_last_i && run_cur != '1) |=> (tag_cnt_o != '0 && tag_last_o));
      end else begin : g_comb
         always_comb begin
            tag_valid_o = lw_valid_i;
            tag_id_o    = lw_id_i;
            tag_cnt_o   = cnt_nxt;
            tag_last_o  = lw_last_i;
            tag_data_o  = lw_data_i;
         end
      end
   endgenerate

endmodule

// File: rtl/txcnt_slot.sv
`timescale 1ns/1ps
module txcnt_slot
   import txcnt_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             hit_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             seen_o,
   output logic             ok_o
);
   logic             seen_q;
   logic             ovf_q;
   logic [CNT_W-1:0] counted_q;
   logic [CNT_W-1:0] recorded_q;
   rec_state_e       rec_st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q     <= 1'b0;
         ovf_q      <= 1'b0;
         counted_q  <= '0;
         recorded_q <= '0;
         rec_st_q   <= REC_NONE;
      end else if (clr_i) begin
         seen_q     <= 1'b0;
         ovf_q      <= 1'b0;
         counted_q  <= '0;
         recorded_q <= '0;
         rec_st_q   <= REC_NONE;
      end else if (hit_i) begin
         seen_q    <= 1'b1;
         counted_q <= counted_q + 1'b1;
         if (counted_q == '1) begin
            ovf_q <= 1'b1;
         end
         if (cnt_i != '0) begin
            recorded_q <= cnt_i;
            rec_st_q   <= rec_step(rec_st_q);
         end
      end
   end

   always_comb begin
      seen_o = seen_q;
      ok_o   = seen_q && (rec_st_q == REC_ONE) && !ovf_q && (recorded_q == counted_q);
   end

   // R8
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clr_i) |=> !ok_o);
   // R4
   slot_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (!seen_o && !ok_o));

endmodule

// File: rtl/txcnt_scan_table.sv
`timescale 1ns/1ps
module txcnt_scan_table
   import txcnt_pkg::*;
#(
   parameter int ID_W  = 4,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scan_start_i,
   input  logic             scan_valid_i,
   input  logic [ID_W-1:0]  scan_id_i,
   input  logic [CNT_W-1:0] scan_cnt_i,
   input  logic             scan_end_i,
   output logic             done_o,
   input  logic [ID_W-1:0]  rd_id_i,
   output logic             rd_seen_o,
   output logic             rd_commit_o
);
   localparam int SLOTS = 1 << ID_W;

   initial begin : param_chk
      assert (ID_W >= 1 && ID_W <= 8) else $error("scan table: ID_W out of range");
      assert (CNT_W >= 2) else $error("scan table: CNT_W too small");
   end

   logic [SLOTS-1:0] seen_v;
   logic [SLOTS-1:0] ok_v;
   logic             done_q;

   genvar g;
   generate
      for (g = 0; g < SLOTS; g++) begin : g_slot
         logic hit;
         assign hit = scan_valid_i && !scan_start_i && (scan_id_i == ID_W'(g));
         txcnt_slot #(.CNT_W(CNT_W)) slot_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (scan_start_i),
            .hit_i  (hit),
            .cnt_i  (scan_cnt_i),
            .seen_o (seen_v[g]),
            .ok_o   (ok_v[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
      end else if (scan_start_i) begin
         done_q <= 1'b0;
      end else if (scan_end_i) begin
         done_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_seen_o   <= 1'b0;
         rd_commit_o <= 1'b0;
      end else begin
         rd_seen_o   <= done_q && seen_v[rd_id_i];
         rd_commit_o <= done_q && ok_v[rd_id_i];
      end
   end

   assign done_o = done_q;

   // R4
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_start_i |=> !done_o);
   // R9
   end_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_end_i && !scan_start_i) |=> done_o);
   // R9
   rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |=> (!rd_seen_o && !rd_commit_o));
   // R5
   rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_commit_o |-> rd_seen_o);

endmodule

// File: rtl/txcnt_commit_top.sv
`timescale 1ns/1ps
module txcnt_commit_top
   import txcnt_pkg::*;
#(
   parameter int ID_W    = 4,
   parameter int CNT_W   = 8,
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lw_valid,
   input  logic [ID_W-1:0]   lw_id,
   input  logic              lw_last,
   input  logic [DATA_W-1:0] lw_data,
   output logic              tag_valid,
   output logic [ID_W-1:0]   tag_id,
   output logic [CNT_W-1:0]  tag_cnt,
   output logic              tag_last,
   output logic [DATA_W-1:0] tag_data,
   input  logic              scan_start,
   input  logic              scan_valid,
   input  logic [ID_W-1:0]   scan_id,
   input  logic [CNT_W-1:0]  scan_cnt,
   input  logic              scan_end,
   output logic              scan_done,
   input  logic [ID_W-1:0]   rd_id,
   output logic              rd_seen,
   output logic              rd_commit
);

   txcnt_tagger #(
      .ID_W(ID_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .OUT_REG(OUT_REG)
   ) tagger_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .lw_valid_i  (lw_valid),
      .lw_id_i     (lw_id),
      .lw_last_i   (lw_last),
      .lw_data_i   (lw_data),
      .tag_valid_o (tag_valid),
      .tag_id_o    (tag_id),
      .tag_cnt_o   (tag_cnt),
      .tag_last_o  (tag_last),
      .tag_data_o  (tag_data)
   );

   txcnt_scan_table #(
      .ID_W(ID_W), .CNT_W(CNT_W)
   ) table_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .scan_start_i (scan_start),
      .scan_valid_i (scan_valid),
      .scan_id_i    (scan_id),
      .scan_cnt_i   (scan_cnt),
      .scan_end_i   (scan_end),
      .done_o       (scan_done),
      .rd_id_i      (rd_id),
      .rd_seen_o    (rd_seen),
      .rd_commit_o  (rd_commit)
   );

   // R10
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!tag_valid && !scan_done));

endmodule

// File: tb/txcnt_commit_top_tb_top.sv
`timescale 1ns/1ps
module txcnt_commit_top_tb_top;
   localparam int ID_W   = 4;
   localparam int CNT_W  = 8;
   localparam int DATA_W = 32;
   localparam int SLOTS  = 1 << ID_W;
   localparam int CMOD   = 1 << CNT_W;
   localparam int MAXE   = 600;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              lw_valid = 1'b0;
   logic [ID_W-1:0]   lw_id = '0;
   logic              lw_last = 1'b0;
   logic [DATA_W-1:0] lw_data = '0;
   logic              tag_valid;
   logic [ID_W-1:0]   tag_id;
   logic [CNT_W-1:0]  tag_cnt;
   logic              tag_last;
   logic [DATA_W-1:0] tag_data;
   logic              scan_start = 1'b0;
   logic              scan_valid = 1'b0;
   logic [ID_W-1:0]   scan_id = '0;
   logic [CNT_W-1:0]  scan_cnt = '0;
   logic              scan_end = 1'b0;
   logic              scan_done;
   logic [ID_W-1:0]   rd_id = '0;
   logic              rd_seen;
   logic              rd_commit;

   always #5 clk = ~clk;

   txcnt_commit_top dut_i (
      .clk(clk), .rst_n(rst_n),
      .lw_valid(lw_valid), .lw_id(lw_id), .lw_last(lw_last), .lw_data(lw_data),
      .tag_valid(tag_valid), .tag_id(tag_id), .tag_cnt(tag_cnt),
      .tag_last(tag_last), .tag_data(tag_data),
      .scan_start(scan_start), .scan_valid(scan_valid), .scan_id(scan_id),
      .scan_cnt(scan_cnt), .scan_end(scan_end), .scan_done(scan_done),
      .rd_id(rd_id), .rd_seen(rd_seen), .rd_commit(rd_commit)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- write-path model ----------------
   int          run_m [SLOTS];
   bit          pend = 1'b0;
   int          p_id, p_cnt, p_last;
   logic [31:0] p_data;

   task automatic log_cycle(input bit v, input int id, input bit last, input logic [31:0] d);
      @(negedge clk);
      if (pend) begin
         chk("R1 tag_valid", tag_valid, 1);
         chk("R1 tag_id", tag_id, p_id);
         chk("R1 tag_last", tag_last, p_last);
         chk("R1 tag_data", tag_data, p_data);
         if (p_last) chk("R3 final count", tag_cnt, p_cnt);
         else        chk("R2 inner count", tag_cnt, 0);
      end else begin
         chk("R1 idle tag_valid", tag_valid, 0);
      end
      lw_valid = v;
      lw_id    = ID_W'(id);
      lw_last  = last;
      lw_data  = d;
      pend     = v;
      if (v) begin
         p_id = id; p_last = int'(last); p_data = d;
         if (last) begin
            p_cnt = (run_m[id] + 1) % CMOD;
            run_m[id] = 0;
         end else begin
            p_cnt = 0;
            run_m[id]++;
         end
      end
   endtask

   // ---------------- recovery-path model ----------------
   int e_id  [MAXE];
   int e_cnt [MAXE];
   int n_ent = 0;

   task automatic add_ent(input int id, input int cnt);
      e_id[n_ent] = id; e_cnt[n_ent] = cnt; n_ent++;
   endtask

   // mode 0 good, 1 one block lost, 2 no count, 3 two counts
   task automatic build_tx(input int id, input int mode);
      int n   = int'($urandom_range(8, 1));
      int pos = int'($urandom_range(n - 1, 0));
      if (mode == 1 && n < 2) n = 2;
      if (mode == 1 && pos > n - 2) pos = n - 2;
      for (int i = 0; i < n; i++) begin
         if (mode == 1 && i == n - 1) continue;
         add_ent(id, (i == pos && mode != 2) ? n : 0);
      end
      if (mode == 3) add_ent(id, n);
   endtask

   task automatic shuffle_ents();
      for (int i = n_ent - 1; i > 0; i--) begin
         int j = int'($urandom_range(i, 0));
         int ti = e_id[i];
         int tc = e_cnt[i];
         e_id[i] = e_id[j]; e_cnt[i] = e_cnt[j];
         e_id[j] = ti;      e_cnt[j] = tc;
      end
   endtask

   function automatic bit exp_seen(input int id);
      int c = 0;
      for (int i = 0; i < n_ent; i++) if (e_id[i] == id) c++;
      return c > 0;
   endfunction

   function automatic bit exp_commit(input int id);
      int c = 0, nz = 0, rec = 0;
      for (int i = 0; i < n_ent; i++) begin
         if (e_id[i] == id) begin
            c++;
            if (e_cnt[i] != 0) begin nz++; rec = e_cnt[i]; end
         end
      end
      return (c > 0) && (nz == 1) && (c <= CMOD - 1) && (rec == c);
   endfunction

   task automatic read_id(input int id, output bit s, output bit c);
      @(negedge clk);
      rd_id = ID_W'(id);
      @(negedge clk);
      s = rd_seen; c = rd_commit;
   endtask

   // Sends the entry list; junk entry on the start cycle for ID SLOTS-1 if asked
   task automatic run_scan(input bit junk_on_start, input int early_id, input string tag);
      bit s, c;
      @(negedge clk);
      scan_start = 1'b1;
      scan_valid = junk_on_start;
      scan_id    = ID_W'(SLOTS - 1);
      scan_cnt   = CNT_W'(1);
      @(negedge clk);
      scan_start = 1'b0;
      scan_valid = 1'b0;
      chk({"R4 done low after start ", tag}, scan_done, 0);
      for (int i = 0; i < n_ent; i++) begin
         scan_valid = 1'b1;
         scan_id    = ID_W'(e_id[i]);
         scan_cnt   = CNT_W'(e_cnt[i]);
         @(negedge clk);
      end
      scan_valid = 1'b0;
      if (early_id >= 0) begin
         read_id(early_id, s, c);
         chk({"R9 seen gated before end ", tag}, s, 0);
         chk({"R9 commit gated before end ", tag}, c, 0);
      end
      scan_end = 1'b1;
      @(negedge clk);
      scan_end = 1'b0;
      chk({"R9 done after end ", tag}, scan_done, 1);
      for (int id = 0; id < SLOTS; id++) begin
         read_id(id, s, c);
         chk({"R5 seen ", tag}, s, exp_seen(id));
         chk({"R5 R7 R8 commit ", tag}, c, exp_commit(id));
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   // ---------------- main ----------------
   initial begin
      bit s, c;
      void'($urandom(32'd715));
      for (int i = 0; i < SLOTS; i++) run_m[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 tag_valid", tag_valid, 0);
      chk("R10 scan_done", scan_done, 0);
      chk("R10 rd_seen", rd_seen, 0);
      chk("R10 rd_commit", rd_commit, 0);

      // R3 single-block transaction
      log_cycle(1'b1, 2, 1'b1, 32'hA5A5_0001);
      // R3 wrap: 255 inner blocks then final gives 256 mod 256 = 0
      for (int i = 0; i < CMOD - 1; i++) log_cycle(1'b1, 6, 1'b0, 32'(i));
      log_cycle(1'b1, 6, 1'b1, 32'hDEAD_0006);
      log_cycle(1'b0, 0, 1'b0, 32'h0);
      // R1 R2 R3 random interleaved IDs with idle gaps
      for (int i = 0; i < 400; i++) begin
         bit v = ($urandom_range(4, 0) != 0);
         log_cycle(v, int'($urandom_range(SLOTS - 1, 0)),
                   ($urandom_range(3, 0) == 0), $urandom);
      end
      log_cycle(1'b0, 0, 1'b0, 32'h0);
      log_cycle(1'b0, 0, 1'b0, 32'h0);

      // R6 count tag at middle, first and last position; R4 junk on start (ID 15)
      n_ent = 0;
      add_ent(3, 0); add_ent(3, 3); add_ent(3, 0);
      add_ent(4, 2); add_ent(4, 0);
      add_ent(5, 0); add_ent(5, 0); add_ent(5, 0); add_ent(5, 4);
      add_ent(11, 0); add_ent(11, 2);
      add_ent(12, 5);
      run_scan(1'b1, 3, "directed order");
      read_id(15, s, c);
      chk("R4 start-cycle entry dropped", s, 0);

      // R7 R8 boundaries
      n_ent = 0;
      for (int i = 0; i < CMOD + 1; i++) add_ent(7, (i == 100) ? 1 : 0);
      for (int i = 0; i < CMOD - 1; i++) add_ent(8, (i == 0) ? CMOD - 1 : 0);
      add_ent(9, 0); add_ent(9, 0);
      add_ent(10, 2); add_ent(10, 2);
      run_scan(1'b0, -1, "boundaries");
      read_id(7, s, c);
      chk("R8 overflowed tally not committed", c, 0);
      read_id(8, s, c);
      chk("R8 full tally committed", c, 1);
      read_id(9, s, c);
      chk("R7 no count not committed", c, 0);
      read_id(10, s, c);
      chk("R7 two counts not committed", c, 0);

      // R5 R6 R7 random scans, shuffled
      for (int r = 0; r < 8; r++) begin
         n_ent = 0;
         for (int id = 0; id < SLOTS; id++) begin
            if ($urandom_range(3, 0) != 0)
               build_tx(id, int'($urandom_range(3, 0)));
         end
         shuffle_ents();
         run_scan(1'b0, (r == 0) ? 0 : -1, "random");
      end

      // R4 new start clears previous verdicts
      @(negedge clk);
      scan_start = 1'b1;
      @(negedge clk);
      scan_start = 1'b0;
      chk("R4 done cleared by start", scan_done, 0);
      scan_end = 1'b1;
      @(negedge clk);
      scan_end = 1'b0;
      n_ent = 0;
      for (int id = 0; id < SLOTS; id++) begin
         read_id(id, s, c);
         chk("R4 empty scan seen", s, 0);
         chk("R4 empty scan commit", c, 0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule